// File: doc/BRIEF.md
# Sector Sequencer with EDC Check

This block receives a raw 2352-byte optical-disc sector as a bit-serial, descrambled stream. Each bit comes with an error flag, and a one-cycle start pulse comes before each sector. The block packs the bits into bytes and writes each byte to a sector buffer. After every eight data bytes it writes one flag byte, which holds the per-byte error flags. While the bytes go by, it reads the mode byte from the header and the form bit from the sub-header. It also runs the 32-bit error detection code (EDC) over the span that the detected format defines.

Once the last byte of a sector has been written, the block writes one status byte. The status byte gives the mode, the form, whether the EDC failed, and whether any error flag was seen. The buffer side is a single write strobe with a 2-bit selector (data, flag or status), a byte index and a data byte. Address generation and memory timing belong to the buffer owner.

Top module: `sector_seq`

## Requirements
- R1: Bits arrive least significant bit first, one per cycle when `bit_vld` is high. Each 8th accepted bit completes a byte. In the cycle after the edge that samples that bit, the block presents one data write: `buf_sel`=0, `buf_idx` = the byte's position in the sector (0..2351), `buf_wdata` = the byte.
- R2: A byte's error flag is the OR of `bit_err` over its 8 bits. One cycle after the data write of byte 8k+7, the block writes a flag byte: `buf_sel`=1, `buf_idx`=k, and bit j set when byte 8k+j was flagged.
- R3: The byte at offset 15 selects the mode. Value 1 gives mode 1, value 2 gives mode 2, and any other value gives mode 0. The mode is reported in status bits 1:0.
- R4: Status bit 2 is bit 5 of byte 18 when the mode is 2, and 0 for every other mode.
- R5: The EDC starts at zero. For each bit, in arrival order: the feedback is the low remainder bit XOR the data bit, the remainder shifts right one place, and the remainder is XORed with D8018001h when the feedback is 1. This is x^32+x^31+x^16+x^15+x^4+x^3+x+1 in reflected form. In mode 1 the EDC covers bytes 0..2063, and the 32-bit result is stored little-endian in bytes 2064..2067. A mismatch sets status bit 3.
- R6: In mode 2 with form bit 0, the EDC covers bytes 16..2071 and is stored in bytes 2072..2075. With form bit 1, it covers bytes 16..2347 and is stored in bytes 2348..2351. A stored field of all zeros in the second case counts as a pass.
- R7: Mode 0 sectors get no EDC check, and status bit 3 stays 0.
- R8: Status bit 4 is set when any byte of the sector was flagged, and bits 7:5 are 0. The status write (`buf_sel`=2, `buf_idx`=0) comes one cycle after the final flag write.
- R9: A `sec_start` pulse clears all sector state, and the bits sampled in that cycle are dropped. Bits that arrive after byte 2351 cause no write until the next `sec_start`.
- R10: While `rst_n` is low, and until a sector is fed after reset, `buf_we` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_start | input | 1 | One-cycle pulse ahead of a sector's first bit |
| bit_vld | input | 1 | Serial bit valid |
| bit_dat | input | 1 | Serial data bit, LSB of each byte first |
| bit_err | input | 1 | Error flag for this bit |
| buf_we | output | 1 | Buffer write strobe |
| buf_sel | output | 2 | 0 data, 1 flag byte, 2 status byte |
| buf_idx | output | IDX_W (12) | Byte, flag-group or status index |
| buf_wdata | output | 8 | Byte to write |

## Verification
The edge that samples a byte's 8th bit makes the data write visible. The flag write for a group of eight is due one edge after the data write of the group's last byte, and the status write one edge after that. The bench records the cycle counter when it drives each bit. It stamps each expected buffer write with that cycle plus one, two or three, and checks each observed write against its stamp as well as its selector, index and data. Any write that appears with no expected item pending is a miscompare. This covers the trailing bits after a sector and the bits of a restarted sector.

// File: rtl/ss_pkg.sv
package ss_pkg;

   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned EDC_W    = 32;
   localparam logic [EDC_W-1:0] EDC_POLY_REFL = 32'hD801_8001;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_FLAG = 2'd1,
      SEL_STAT = 2'd2
   } buf_sel_e;

   // one byte through the reflected EDC, LSB first
   function automatic logic [EDC_W-1:0] edc_byte(input logic [EDC_W-1:0] rem_in,
                                                 input logic [BYTE_W-1:0] dat);
      logic [EDC_W-1:0] r;
      logic fb;
      r = rem_in;
      for (int b = 0; b < BYTE_W; b++) begin
         fb = r[0] ^ dat[b];
         r  = r >> 1;
         if (fb) r = r ^ EDC_POLY_REFL;
      end
      return r;
   endfunction

   function automatic logic [1:0] mode_decode(input logic [BYTE_W-1:0] b);
      if (b == 8'd1)      return 2'd1;
      else if (b == 8'd2) return 2'd2;
      else                return 2'd0;
   endfunction

endpackage

// File: rtl/ss_deser.sv
module ss_deser
   import ss_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              accept,
   input  logic              bit_vld,
   input  logic              bit_dat,
   input  logic              bit_err,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_dat,
   output logic              byte_err
);
   localparam int unsigned CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

   logic [BYTE_W-2:0] shift_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              errs_q;
   logic              take;

   assign take     = bit_vld && accept;
   assign byte_vld = take && (cnt_q == CNT_LAST);
   assign byte_dat = {bit_dat, shift_q};
   assign byte_err = errs_q | bit_err;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         shift_q <= '0;
         cnt_q   <= '0;
         errs_q  <= 1'b0;
      end else if (take) begin
         shift_q <= {bit_dat, shift_q[BYTE_W-2:1]};
         cnt_q   <= cnt_q + 1'b1;
         errs_q  <= (cnt_q == CNT_LAST) ? 1'b0 : (errs_q | bit_err);
      end
   end

endmodule

// File: rtl/ss_edc.sv
module ss_edc
   import ss_pkg::*;
#(
   parameter int unsigned IDX_W = 12,
   parameter int unsigned START = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              in_vld,
   input  logic [BYTE_W-1:0] in_dat,
   input  logic [IDX_W-1:0]  in_idx,
   output logic [EDC_W-1:0]  rem
);
   logic hit;

   generate
      if (START == 0) begin : g_from_first
         logic [IDX_W-1:0] idx_unused;
         assign idx_unused = in_idx;
         assign hit = in_vld;
      end else begin : g_from_offset
         localparam logic [IDX_W-1:0] START_I = IDX_W'(START);
         assign hit = in_vld && (in_idx >= START_I);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr)  rem <= '0;
      else if (hit)       rem <= edc_byte(rem, in_dat);
   end

endmodule

// File: rtl/ss_ctl.sv
module ss_ctl
   import ss_pkg::*;
#(
   parameter int unsigned SEC_BYTES    = 2352,
   parameter int unsigned MODE_OFS     = 15,
   parameter int unsigned SUBH_OFS     = 18,
   parameter int unsigned FORM_BIT     = 5,
   parameter int unsigned M1_EDC_END   = 2067,
   parameter int unsigned M2F1_EDC_END = 2075,
   parameter int unsigned IDX_W        = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_start,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_dat,
   input  logic              byte_err,
   input  logic [EDC_W-1:0]  rem_full,
   input  logic [EDC_W-1:0]  rem_late,
   output logic              accept,
   output logic [IDX_W-1:0]  cur_idx,
   output logic              buf_we,
   output logic [1:0]        buf_sel,
   output logic [IDX_W-1:0]  buf_idx,
   output logic [BYTE_W-1:0] buf_wdata
);
   localparam int unsigned FLAG_W = IDX_W - 3;
   localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(SEC_BYTES - 1);
   localparam logic [IDX_W-1:0] FLD_I   = IDX_W'(SEC_BYTES - 4);
   localparam logic [IDX_W-1:0] MODE_I  = IDX_W'(MODE_OFS);
   localparam logic [IDX_W-1:0] SUBH_I  = IDX_W'(SUBH_OFS);
   localparam logic [IDX_W-1:0] M1END_I = IDX_W'(M1_EDC_END);
   localparam logic [IDX_W-1:0] F1END_I = IDX_W'(M2F1_EDC_END);

   logic              active_q;
   logic [IDX_W-1:0]  bidx_q;
   logic [FLAG_W-1:0] fidx_q;
   logic [1:0]        mode_q;
   logic              form_q;
   logic              err_seen_q;
   logic              edc_fail_q;
   logic              fld_nz_q;
   logic [BYTE_W-1:0] flag_acc_q;
   logic              pend_flag_q;
   logic              pend_stat_q;
   buf_sel_e          sel_q;

   logic              edc_due;
   logic              edc_bad;
   logic [BYTE_W-1:0] stat_byte;

   assign accept  = active_q && !sec_start;
   assign cur_idx = bidx_q;
   assign buf_sel = sel_q;

   // EDC verdict: due when the data write of the range's last stored byte is out
   always_comb begin
      edc_due = 1'b0;
      edc_bad = 1'b0;
      unique case (mode_q)
         2'd1: begin
            edc_due = (buf_idx == M1END_I);
            edc_bad = (rem_full != '0);
         end
         2'd2: begin
            if (form_q) begin
               edc_due = (buf_idx == LAST_I);
               edc_bad = fld_nz_q && (rem_late != '0);
            end else begin
               edc_due = (buf_idx == F1END_I);
               edc_bad = (rem_late != '0);
            end
         end
         default: ;
      endcase
   end

   assign stat_byte = {3'b000, err_seen_q, edc_fail_q,
                       form_q & (mode_q == 2'd2), mode_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q    <= 1'b0;
         bidx_q      <= '0;
         fidx_q      <= '0;
         mode_q      <= '0;
         form_q      <= 1'b0;
         err_seen_q  <= 1'b0;
         edc_fail_q  <= 1'b0;
         fld_nz_q    <= 1'b0;
         flag_acc_q  <= '0;
         pend_flag_q <= 1'b0;
         pend_stat_q <= 1'b0;
         buf_we      <= 1'b0;
         sel_q       <= SEL_DATA;
         buf_idx     <= '0;
         buf_wdata   <= '0;
      end else begin
         buf_we <= 1'b0;
         if (sec_start) begin
            active_q    <= 1'b1;
            bidx_q      <= '0;
            fidx_q      <= '0;
            mode_q      <= '0;
            form_q      <= 1'b0;
            err_seen_q  <= 1'b0;
            edc_fail_q  <= 1'b0;
            fld_nz_q    <= 1'b0;
            flag_acc_q  <= '0;
            pend_flag_q <= 1'b0;
            pend_stat_q <= 1'b0;
         end else begin
            if (byte_vld) begin
               buf_we                  <= 1'b1;
               sel_q                   <= SEL_DATA;
               buf_idx                 <= bidx_q;
               buf_wdata               <= byte_dat;
               bidx_q                  <= bidx_q + 1'b1;
               flag_acc_q[bidx_q[2:0]] <= byte_err;
               err_seen_q              <= err_seen_q | byte_err;
               if (bidx_q == MODE_I) mode_q <= mode_decode(byte_dat);
               if (bidx_q == SUBH_I) form_q <= byte_dat[FORM_BIT];
               if (bidx_q >= FLD_I)  fld_nz_q <= fld_nz_q | (|byte_dat);
               if (bidx_q[2:0] == 3'd7) pend_flag_q <= 1'b1;
               if (bidx_q == LAST_I) begin
                  pend_stat_q <= 1'b1;
                  active_q    <= 1'b0;
               end
            end else if (pend_flag_q) begin
               buf_we      <= 1'b1;
               sel_q       <= SEL_FLAG;
               buf_idx     <= {3'b000, fidx_q};
               buf_wdata   <= flag_acc_q;
               fidx_q      <= fidx_q + 1'b1;
               pend_flag_q <= 1'b0;
            end else if (pend_stat_q) begin
               buf_we      <= 1'b1;
               sel_q       <= SEL_STAT;
               buf_idx     <= '0;
               buf_wdata   <= stat_byte;
               pend_stat_q <= 1'b0;
            end
            if (buf_we && (sel_q == SEL_DATA) && edc_due)
               edc_fail_q <= edc_bad;
         end
      end
   end

   // a flag byte always trails the data write that closed its group
   assert_flag_after_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && buf_sel == SEL_FLAG) |-> $past(buf_we && buf_sel == SEL_DATA));

   // the status byte always trails the last flag write
   assert_status_after_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && buf_sel == SEL_STAT) |-> $past(buf_we && buf_sel == SEL_FLAG));

   // no data write may follow a cycle in which bits were refused
   assert_idle_no_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> !(buf_we && buf_sel == SEL_DATA));

   // form bit only reported for mode 2, upper bits clear
   assert_status_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && buf_sel == SEL_STAT && buf_wdata[1:0] != 2'd2)
         |-> (!buf_wdata[2] && buf_wdata[7:5] == 3'b000));

endmodule

// File: rtl/sector_seq.sv
module sector_seq
   import ss_pkg::*;
#(
   parameter int unsigned SEC_BYTES    = 2352,
   parameter int unsigned MODE_OFS     = 15,
   parameter int unsigned SUBH_OFS     = 18,
   parameter int unsigned FORM_BIT     = 5,
   parameter int unsigned M2_START     = 16,
   parameter int unsigned M1_EDC_END   = 2067,
   parameter int unsigned M2F1_EDC_END = 2075,
   parameter int unsigned IDX_W        = $clog2(SEC_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sec_start,
   input  logic             bit_vld,
   input  logic             bit_dat,
   input  logic             bit_err,
   output logic             buf_we,
   output logic [1:0]       buf_sel,
   output logic [IDX_W-1:0] buf_idx,
   output logic [7:0]       buf_wdata
);
   localparam int unsigned N_EDC = 2;

   generate
      if (SEC_BYTES % BYTE_W != 0) begin : g_bad_len
         $error("sector length must be a whole number of flag groups");
      end
      if (M1_EDC_END >= SEC_BYTES || M2F1_EDC_END >= SEC_BYTES) begin : g_bad_end
         $error("EDC field must lie inside the sector");
      end
      if (MODE_OFS >= M2_START || SUBH_OFS >= M2F1_EDC_END) begin : g_bad_hdr
         $error("header fields must precede the EDC verdicts");
      end
      if (FORM_BIT >= BYTE_W || IDX_W < 4) begin : g_bad_w
         $error("form bit or index width out of range");
      end
   endgenerate

   logic              byte_vld;
   logic [BYTE_W-1:0] byte_dat;
   logic              byte_err;
   logic              accept;
   logic [IDX_W-1:0]  cur_idx;
   logic [EDC_W-1:0]  rem [N_EDC];

   ss_deser u_deser (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (sec_start),
      .accept   (accept),
      .bit_vld  (bit_vld),
      .bit_dat  (bit_dat),
      .bit_err  (bit_err),
      .byte_vld (byte_vld),
      .byte_dat (byte_dat),
      .byte_err (byte_err)
   );

   // engine 0 covers the whole sector, engine 1 starts after the header
   for (genvar g = 0; g < N_EDC; g++) begin : g_edc
      ss_edc #(
         .IDX_W (IDX_W),
         .START ((g == 0) ? 0 : M2_START)
      ) u_edc (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (sec_start),
         .in_vld (byte_vld),
         .in_dat (byte_dat),
         .in_idx (cur_idx),
         .rem    (rem[g])
      );
   end

   ss_ctl #(
      .SEC_BYTES    (SEC_BYTES),
      .MODE_OFS     (MODE_OFS),
      .SUBH_OFS     (SUBH_OFS),
      .FORM_BIT     (FORM_BIT),
      .M1_EDC_END   (M1_EDC_END),
      .M2F1_EDC_END (M2F1_EDC_END),
      .IDX_W        (IDX_W)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sec_start (sec_start),
      .byte_vld  (byte_vld),
      .byte_dat  (byte_dat),
      .byte_err  (byte_err),
      .rem_full  (rem[0]),
      .rem_late  (rem[1]),
      .accept    (accept),
      .cur_idx   (cur_idx),
      .buf_we    (buf_we),
      .buf_sel   (buf_sel),
      .buf_idx   (buf_idx),
      .buf_wdata (buf_wdata)
   );

endmodule

// File: tb/sector_seq_tb_top.sv
`timescale 1ns/1ps
module sector_seq_tb_top;
   localparam int NB = 2352;
   localparam int K_M1 = 0, K_F1 = 1, K_F2 = 2, K_F2Z = 3, K_OTH = 4;

   logic clk = 1'b0, rst_n = 1'b0, sec_start = 1'b0;
   logic bit_vld = 1'b0, bit_dat = 1'b0, bit_err = 1'b0;
   logic buf_we;
   logic [1:0] buf_sel;
   logic [11:0] buf_idx;
   logic [7:0] buf_wdata;

   sector_seq dut_i (
      .clk(clk), .rst_n(rst_n), .sec_start(sec_start),
      .bit_vld(bit_vld), .bit_dat(bit_dat), .bit_err(bit_err),
      .buf_we(buf_we), .buf_sel(buf_sel), .buf_idx(buf_idx), .buf_wdata(buf_wdata)
   );

   always #2.5 clk = ~clk;

   int unsigned cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      logic [1:0]  sel;
      int          idx;
      logic [7:0]  dat;
      int unsigned at;
      string       req;
   } exp_t;

   exp_t q[$];
   int n_chk = 0, n_fail = 0, n_unexp = 0;
   bit done = 1'b0;
   logic [7:0] sec [NB];
   bit errb [NB];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && buf_we && !done) begin
         n_chk++;
         if (q.size() == 0) begin
            n_fail++;
            n_unexp++;
            $display("FAIL R9 unexpected write: actual sel=%0d idx=%0d dat=%02h cyc=%0d expected none",
                     buf_sel, buf_idx, buf_wdata, cyc);
         end else begin
            exp_t e;
            e = q.pop_front();
            if (buf_sel != e.sel || int'(buf_idx) != e.idx || buf_wdata != e.dat || cyc != e.at) begin
               n_fail++;
               $display("FAIL %s write: actual sel=%0d idx=%0d dat=%02h cyc=%0d expected sel=%0d idx=%0d dat=%02h cyc=%0d",
                        e.req, buf_sel, buf_idx, buf_wdata, cyc, e.sel, e.idx, e.dat, e.at);
            end
         end
      end
   end

   function automatic logic [31:0] edc_calc(input int lo, input int hi);
      logic [31:0] c;
      c = '0;
      for (int i = lo; i <= hi; i++) begin
         for (int b = 0; b < 8; b++) begin
            logic fb;
            fb = c[0] ^ sec[i][b];
            c = c >> 1;
            if (fb) c = c ^ 32'hD801_8001;
         end
      end
      return c;
   endfunction

   function automatic logic [31:0] field_at(input int a);
      return {sec[a+3], sec[a+2], sec[a+1], sec[a]};
   endfunction

   task automatic store_edc(input int lo, input int hi, input int at);
      logic [31:0] c;
      c = edc_calc(lo, hi);
      for (int k = 0; k < 4; k++) sec[at+k] = c[8*k +: 8];
   endtask

   task automatic build(input int kind, input int seed, input bit corrupt);
      for (int i = 0; i < NB; i++) begin
         sec[i] = 8'((i * seed + (i >> 3)) ^ 8'h5A);
         errb[i] = 1'b0;
      end
      case (kind)
         K_M1:  begin sec[15] = 8'd1; sec[18] = sec[18] | 8'h20; store_edc(0, 2063, 2064); end
         K_F1:  begin sec[15] = 8'd2; sec[18] = sec[18] & 8'hDF; store_edc(16, 2071, 2072); end
         K_F2:  begin sec[15] = 8'd2; sec[18] = sec[18] | 8'h20; store_edc(16, 2347, 2348); end
         K_F2Z: begin
            sec[15] = 8'd2; sec[18] = sec[18] | 8'h20;
            for (int k = 0; k < 4; k++) sec[2348+k] = 8'h00;
         end
         default: begin sec[15] = 8'd3; sec[18] = sec[18] | 8'h20; end
      endcase
      if (corrupt) sec[1000] = sec[1000] ^ 8'h01;
   endtask

   // status computed from R3..R8
   function automatic logic [7:0] exp_status();
      logic [1:0] md;
      logic fm, fail, anyerr;
      md = (sec[15] == 8'd1) ? 2'd1 : (sec[15] == 8'd2) ? 2'd2 : 2'd0;
      fm = (md == 2'd2) ? sec[18][5] : 1'b0;
      fail = 1'b0;
      if (md == 2'd1) fail = (edc_calc(0, 2063) != field_at(2064));
      else if (md == 2'd2 && !fm) fail = (edc_calc(16, 2071) != field_at(2072));
      else if (md == 2'd2 && fm)
         fail = (field_at(2348) != 32'h0) && (edc_calc(16, 2347) != field_at(2348));
      anyerr = 1'b0;
      for (int i = 0; i < NB; i++) anyerr = anyerr | errb[i];
      return {3'b000, anyerr, fail, fm, md};
   endfunction

   task automatic send(input int nbytes, input int extra, input string stag);
      logic [7:0] st;
      logic [7:0] fl;
      st = exp_status();
      @(negedge clk);
      sec_start = 1'b1;
      bit_vld = 1'b1;     // bits in the start cycle are dropped (R9)
      bit_dat = 1'b1;
      @(negedge clk);
      sec_start = 1'b0;
      for (int i = 0; i < nbytes; i++) begin
         for (int b = 0; b < 8; b++) begin
            bit_vld = 1'b1;
            bit_dat = sec[i][b];
            bit_err = errb[i] && (b == 3);
            if (b == 7) begin
               q.push_back('{sel: 2'd0, idx: i, dat: sec[i], at: cyc + 1, req: "R1"});
               if (i % 8 == 7) begin
                  for (int j = 0; j < 8; j++) fl[j] = errb[i-7+j];
                  q.push_back('{sel: 2'd1, idx: i / 8, dat: fl, at: cyc + 2, req: "R2"});
               end
               if (i == NB - 1)
                  q.push_back('{sel: 2'd2, idx: 0, dat: st, at: cyc + 3, req: stag});
            end
            @(negedge clk);
         end
      end
      bit_err = 1'b0;
      for (int x = 0; x < extra; x++) begin
         bit_vld = 1'b1;
         bit_dat = x[0];
         @(negedge clk);
      end
      bit_vld = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(buf_we == 1'b0, "R10", "write strobe in reset", buf_we, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(buf_we == 1'b0, "R10", "write strobe after reset", buf_we, 0);

      // R9: restart mid-sector with flagged bytes; the next sector must not inherit them
      build(K_M1, 3, 1'b0);
      errb[5] = 1'b1; errb[17] = 1'b1;
      send(100, 0, "R9");
      build(K_M1, 3, 1'b0);
      send(NB, 0, "R9 R5 R4 mode1 good");          // 0x01

      build(K_M1, 5, 1'b1);
      errb[100] = 1'b1; errb[NB-1] = 1'b1;
      send(NB, 0, "R5 R8 mode1 bad");              // 0x19

      build(K_F1, 7, 1'b0);
      send(NB, 0, "R6 form1 good");                // 0x02
      build(K_F1, 9, 1'b1);
      send(NB, 0, "R6 form1 bad");                 // 0x0A
      build(K_F2Z, 11, 1'b0);
      send(NB, 0, "R6 form2 zero field");          // 0x06
      build(K_F2, 13, 1'b0);
      errb[2300] = 1'b1;
      send(NB, 0, "R6 R8 form2 good");             // 0x16

      build(K_OTH, 17, 1'b1);
      send(NB, 24, "R3 R7 other mode");            // 0x00, trailing bits
      check(n_unexp == 0, "R9", "writes from trailing bits", n_unexp, 0);

      repeat (10) @(negedge clk);
      check(q.size() == 0, "R8", "expected writes left over", q.size(), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule